// File: doc/BRIEF.md
# Filtered Pulse Width and Period Timer

This block times a digital waveform in units of a programmable base tick. One of three trigger lines is picked and synchronised into the system clock. A stable-sample glitch filter then cleans it, and edges are taken from the filtered level. A measurement is armed by `start`. It waits for the edge that opens the selected interval, counts base ticks, and latches the count into a result register when the closing edge arrives.

Four measurement kinds exist. The first three time one quantity each: the high phase, the low phase, or the full cycle from falling edge to falling edge. The fourth runs once over a single cycle and returns both the low phase and the full period. The base tick comes from a divider on the system clock, so one count stands for `div_m1 + 1` clock cycles. A run that lasts longer than the counter can hold stops at the maximum count and raises an overflow flag.

Top module: `pulse_timer`

## Requirements
- R1: After a synchronous reset, `meas_q` and `low_q` read 0 and `done_q`, `ovf_q` and `busy_q` read 0.
- R2: With `mode` = 0 (high width), the result is the number of base ticks from a rising to the following falling edge of the filtered input.
- R3: With `mode` = 1 (low width), the result is the number of base ticks from a falling to the following rising edge.
- R4: With `mode` = 2 (period), the result is the number of base ticks from a falling edge to the next falling edge.
- R5: With `mode` = 3 (dual), a single run leaves the falling-to-rising tick count in `low_q` and the falling-to-falling tick count in `meas_q`.
- R6: `src_sel` = 0, 1 or 2 picks `trig_in[0]`, `trig_in[1]` or `trig_in[2]`, and the value 3 also picks `trig_in[2]`. Activity on lines that are not selected does not affect a measurement.
- R7: The filtered level takes a new value only after the synchronised input has held that value for FILT_LEN (default 3) consecutive base ticks. Shorter excursions of either polarity are ignored, and levels held at least that long keep their exact length in ticks.
- R8: A base tick occurs once every `div_m1 + 1` clock cycles, and all results are in base ticks.
- R9: `start` clears `done_q` and `ovf_q`, sets `busy_q`, and takes the values of `mode` and `src_sel` for the whole run. When the run completes, `done_q` is set and `busy_q` is cleared.
- R10: If the count passes 2^CW - 1 before the closing edge, the result reads 2^CW - 1 and `ovf_q` is set. A width of exactly 2^CW - 1 ticks reads that value with `ovf_q` clear.
- R11: Edges that arrive while no run is armed leave `meas_q`, `low_q` and `done_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a new measurement and latches the mode and source |
| mode | input | 2 | 0 high width, 1 low width, 2 period, 3 dual low width and period |
| src_sel | input | 2 | Trigger line select |
| trig_in | input | 3 | Candidate trigger lines |
| div_m1 | input | DW | Base tick divider minus one |
| meas_q | output | CW | Width or period result in base ticks |
| low_q | output | CW | Low-width result of a dual run |
| done_q | output | 1 | Run complete; cleared by start |
| ovf_q | output | 1 | Last run saturated |
| busy_q | output | 1 | A run is armed or counting |

## Verification
The assertions assume that `div_m1` does not change while a run is active. They also assume that every level phase that is meant to be measured lasts at least FILT_LEN base ticks, so the dual run always sees a low phase shorter than its period. The stimulus changes the divider only between runs. It holds every level for a whole multiple of the divide ratio and never for fewer than three ticks, except for the deliberate glitches. Trigger lines rest high before each run is started.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  typedef enum logic [1:0] {
    MODE_HIGH   = 2'd0,
    MODE_LOW    = 2'd1,
    MODE_PERIOD = 2'd2,
    MODE_DUAL   = 2'd3
  } meas_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_RUN2 = 2'd3
  } meas_state_e;

endpackage

// File: rtl/ptm_tick_gen.sv
module ptm_tick_gen #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] div_m1,
  output logic          tick
);

  logic [DW-1:0] div_cnt_q;

  // greater-or-equal so a divider lowered mid-count still wraps at once
  assign tick = (div_cnt_q >= div_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt_q <= '0;
    end else if (tick) begin
      div_cnt_q <= '0;
    end else begin
      div_cnt_q <= div_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ptm_filter.sv
module ptm_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic rise,
  output logic fall
);

  localparam int RW = $clog2(FILT_LEN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw;
  logic [RW-1:0]          run_q;
  logic                   filt_q;
  logic                   filt_d_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= din;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate

  assign raw = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw == filt_q) begin
      run_q <= '0;
    end else if (tick) begin
      if (run_q == RUN_LAST) begin
        filt_q <= raw;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) filt_d_q <= 1'b0;
    else     filt_d_q <= filt_q;
  end

  assign rise = filt_q & ~filt_d_q;
  assign fall = ~filt_q & filt_d_q;

  AST_FILT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> $past(tick)); // R7
  AST_FILT_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(raw))); // R7

endmodule

// File: rtl/ptm_core.sv
module ptm_core
  import ptm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          tick,
  input  logic          rise,
  input  logic          fall,
  output logic [CW-1:0] meas_q,
  output logic [CW-1:0] low_q,
  output logic          done_q,
  output logic          ovf_q,
  output logic          busy_q
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  meas_mode_e    mode_q;
  meas_state_e   st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] sum;
  logic          sat_q;
  logic          wrap;
  logic          open_evt;
  logic          close_evt;

  always_comb begin
    wrap = tick && (cnt_q == CNT_MAX);
    sum  = wrap ? CNT_MAX : cnt_q + CW'(tick);
    open_evt = (mode_q == MODE_HIGH) ? rise : fall;
    case (mode_q)
      MODE_HIGH:   close_evt = fall;
      MODE_LOW:    close_evt = rise;
      MODE_PERIOD: close_evt = fall;
      default:     close_evt = rise; // dual: mid-point in first run phase
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_HIGH;
      cnt_q  <= '0;
      sat_q  <= 1'b0;
      meas_q <= '0;
      low_q  <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (start) begin
      st_q   <= ST_ARM;
      mode_q <= meas_mode_e'(mode);
      cnt_q  <= '0;
      sat_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_ARM: begin
          if (open_evt) begin
            cnt_q <= '0;
            sat_q <= 1'b0;
            st_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_q <= sum;
          sat_q <= sat_q | wrap;
          if (close_evt) begin
            if (mode_q == MODE_DUAL) begin
              low_q <= sum;
              st_q  <= ST_RUN2;
            end else begin
              meas_q <= sum;
              ovf_q  <= sat_q | wrap;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end
        end
        ST_RUN2: begin
          cnt_q <= sum;
          sat_q <= sat_q | wrap;
          if (fall) begin
            meas_q <= sum;
            ovf_q  <= sat_q | wrap;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_q = (st_q != ST_IDLE);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q); // R9
  AST_START_REARMS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done_q && !ovf_q && busy_q)); // R9
  AST_SAT_RESULT: assert property (@(posedge clk) disable iff (rst)
    (done_q && ovf_q) |-> (meas_q == CNT_MAX)); // R10
  AST_DUAL_ORDER: assert property (@(posedge clk) disable iff (rst)
    (done_q && !ovf_q && mode_q == MODE_DUAL) |-> (low_q < meas_q)); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> ($stable(meas_q) && $stable(low_q) && done_q)); // R11

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CW          = 16,
  parameter int DW          = 4,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int NSRC        = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [1:0]      src_sel,
  input  logic [NSRC-1:0] trig_in,
  input  logic [DW-1:0]   div_m1,
  output logic [CW-1:0]   meas_q,
  output logic [CW-1:0]   low_q,
  output logic            done_q,
  output logic            ovf_q,
  output logic            busy_q
);

  logic [1:0] src_q;
  logic       trig_sel;
  logic       tick;
  logic       rise;
  logic       fall;

  always_ff @(posedge clk) begin
    if (rst)        src_q <= '0;
    else if (start) src_q <= src_sel;
  end

  // codes past the last line all map onto the last line
  always_comb begin
    trig_sel = trig_in[NSRC-1];
    for (int i = 0; i < NSRC; i++) begin
      if (int'(src_q) == i) trig_sel = trig_in[i];
    end
  end

  ptm_tick_gen #(.DW(DW)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .div_m1 (div_m1),
    .tick   (tick)
  );

  ptm_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .din  (trig_sel),
    .rise (rise),
    .fall (fall)
  );

  ptm_core #(.CW(CW)) u_core (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mode   (mode),
    .tick   (tick),
    .rise   (rise),
    .fall   (fall),
    .meas_q (meas_q),
    .low_q  (low_q),
    .done_q (done_q),
    .ovf_q  (ovf_q),
    .busy_q (busy_q)
  );

endmodule

// File: tb/test_pulse_timer.sv
module test_pulse_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  src_sel = 2'd0;
  logic [2:0]  trig = 3'b111;
  logic [3:0]  div_m1 = 4'd0;
  logic [15:0] meas_q, low_q;
  logic        done_q, ovf_q, busy_q;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk; // 125 MHz

  pulse_timer i_pulse_timer (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .src_sel(src_sel),
    .trig_in(trig), .div_m1(div_m1), .meas_q(meas_q), .low_q(low_q),
    .done_q(done_q), .ovf_q(ovf_q), .busy_q(busy_q)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] lo;
    logic [15:0] hi;
    logic [15:0] exp_a;
    logic [15:0] exp_b;
  } vec_t;

  // waveform: idle high, low lo, high hi, low tail, high
  localparam vec_t VECS [7] = '{
    '{2'd0, 16'd5,  16'd7,  16'd7,  16'd0},
    '{2'd1, 16'd9,  16'd4,  16'd9,  16'd0},
    '{2'd2, 16'd6,  16'd8,  16'd14, 16'd0},
    '{2'd3, 16'd4,  16'd10, 16'd14, 16'd4},
    '{2'd0, 16'd3,  16'd3,  16'd3,  16'd0},
    '{2'd3, 16'd20, 16'd3,  16'd23, 16'd20},
    '{2'd2, 16'd3,  16'd3,  16'd6,  16'd0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wave(input int line, input int lo, input int hi, input int sc);
    trig[line] = 1'b0; cyc(lo * sc);
    trig[line] = 1'b1; cyc(hi * sc);
    trig[line] = 1'b0; cyc(10 * sc);
    trig[line] = 1'b1; cyc(12 * sc + 10);
  endtask

  task automatic arm(input int md, input int src, input int dv);
    mode = md[1:0]; src_sel = src[1:0]; div_m1 = dv[3:0];
    start = 1'b1; cyc(1);
    start = 1'b0; cyc(5);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    check("R1", "meas", meas_q, 0);
    check("R1", "low", low_q, 0);
    check("R1", "done", done_q, 0);
    check("R1", "ovf", ovf_q, 0);
    check("R1", "busy", busy_q, 0);
    cyc(20);

    // R2 R3 R4 R5: table of modes
    for (int v = 0; v < 7; v++) begin
      arm(VECS[v].md, 0, 0);
      wave(0, VECS[v].lo, VECS[v].hi, 1);
      check("R2/R3/R4 table", "meas", meas_q, VECS[v].exp_a);
      check("R9 table", "done", done_q, 1);
      check("R9 table", "busy", busy_q, 0);
      if (VECS[v].md == 2'd3) check("R5 table", "low", low_q, VECS[v].exp_b);
    end

    // R11: edges while idle leave the result alone
    wave(0, 6, 6, 1);
    check("R11", "meas after idle edges", meas_q, 6);
    check("R11", "done after idle edges", done_q, 1);

    // R9: start clears done, mode latched at start
    arm(1, 0, 0);
    check("R9", "done cleared", done_q, 0);
    check("R9", "busy set", busy_q, 1);
    mode = 2'd0;
    wave(0, 8, 5, 1);
    check("R9", "latched mode result", meas_q, 8);

    // R6: source selection
    arm(1, 1, 0);
    wave(0, 9, 4, 1);
    check("R6", "unselected line ignored", done_q, 0);
    wave(1, 9, 4, 1);
    check("R6", "line 1 result", meas_q, 9);
    arm(1, 3, 0);
    wave(2, 11, 4, 1);
    check("R6", "code 3 uses line 2", meas_q, 11);
    arm(1, 2, 0);
    wave(2, 13, 4, 1);
    check("R6", "code 2 uses line 2", meas_q, 13);

    // R7: glitches of both polarities
    arm(0, 0, 0);
    trig[0] = 1'b0; cyc(20);
    trig[0] = 1'b1; cyc(2);
    trig[0] = 1'b0; cyc(20);
    check("R7", "short high ignored (done)", done_q, 0);
    check("R7", "short high ignored (busy)", busy_q, 1);
    trig[0] = 1'b1; cyc(5);
    trig[0] = 1'b0; cyc(2);
    trig[0] = 1'b1; cyc(5);
    trig[0] = 1'b0; cyc(20);
    trig[0] = 1'b1; cyc(20);
    check("R7", "short low inside pulse", meas_q, 12);

    // R8: divided base tick
    arm(0, 0, 3);
    wave(0, 4, 6, 4);
    check("R8", "high width div4", meas_q, 6);
    arm(2, 0, 3);
    wave(0, 3, 5, 4);
    check("R8", "period div4", meas_q, 8);
    arm(3, 0, 1);
    wave(0, 5, 7, 2);
    check("R8", "dual period div2", meas_q, 12);
    check("R8", "dual low div2", low_q, 5);

    // R10: exact maximum, then saturation
    arm(0, 0, 0);
    wave(0, 5, 65535, 1);
    check("R10", "max width value", meas_q, 65535);
    check("R10", "max width no ovf", ovf_q, 0);
    arm(0, 0, 0);
    wave(0, 5, 66000, 1);
    check("R10", "saturated value", meas_q, 65535);
    check("R10", "ovf flag", ovf_q, 1);
    arm(0, 0, 0);
    check("R10", "ovf cleared by start", ovf_q, 0);
    wave(0, 5, 4, 1);
    check("R10", "after ovf run", meas_q, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule